// File: doc/BRIEF.md
# Two-Lane Unfolded Delay-Tap Filter

This block computes the feed-forward filter y(n) = a·x(n−9) + x(n) at two samples per clock. The stream is unfolded by a factor of two. Each accepted input block k carries the even sample x(2k) on lane 0 and the odd sample x(2k+1) on lane 1. The block returns the matching pair y(2k) and y(2k+1) one clock later. A single multiply-add per lane therefore completes two filter iterations in every clock.

The nine-sample delay does not divide evenly between two lanes. Each output lane reads its delayed operand from the opposite lane. The even output takes the odd-lane sample from five blocks earlier, x(2(k−5)+1). The odd output takes the even-lane sample from four blocks earlier, x(2(k−4)). Each lane therefore has its own short shift register, and the registers are of unequal depth. They advance only on accepted blocks, so idle cycles do not change the sample history. The tap distance and the lane count are parameters. The block depths and the source lanes are computed from them.

The parent supplies a serial-to-parallel converted stream with a valid strobe and a signed coefficient. It receives a two-lane result bus with its own valid.

Top module: `unfold2_tap_filter`

## Requirements
- R1: A synchronous active-high `rst` clears every delay stage, `out_valid` and `out_data` to zero at the next rising clock edge.
- R2: `out_valid` equals the `in_valid` of the previous clock cycle.
- R3: For an accepted block k, the even result is coef·x(2k−9) + x(2k). Here x(2k−9) is the odd-lane sample of the fifth accepted block before block k.
- R4: For an accepted block k, the odd result is coef·x(2k−8) + x(2k+1). Here x(2k−8) is the even-lane sample of the fourth accepted block before block k.
- R5: A delayed operand whose sample index is negative, counted from the last reset, reads as zero. During fill, each result therefore equals its current-lane sample.
- R6: A cycle with `in_valid` low advances no delay line. The following cycle shows `out_valid` low and leaves `out_data` unchanged.
- R7: Results are 33-bit two's complement and never overflow, including the case −32768·−32768 + 32767 = 1073774591.
- R8: Lane positions: the even sample is `in_data[15:0]` and the odd sample is `in_data[31:16]`. The even result is `out_data[32:0]` and the odd result is `out_data[65:33]`. Every field is signed two's complement.
- R9: Each result uses the `coef` value present in the same cycle as its input block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block strobe |
| in_data | input | 32 | Two signed 16-bit samples, even sample in the low half |
| coef | input | 16 | Signed coefficient a |
| out_valid | output | 1 | Result block strobe, one cycle after the input strobe |
| out_data | output | 66 | Two signed 33-bit results, even result in the low part |

## Verification
The two functions that meet in one cycle are the shift of both delay lines and the multiply-add that reads their oldest stages. In that cycle the even lane reads a sample that left the odd lane five blocks earlier, while the odd lane takes in its own new sample. The bench provokes this collision with long runs of back-to-back blocks, random idle gaps and a coefficient that changes every cycle. It also places extreme values directly across the lane boundary. Each result pair is judged against a full sample history held in the bench, indexed by true sample number, so a wrong depth or a swapped source lane shows up as a mismatch.

// File: rtl/ufir_pkg.sv
package ufir_pkg;

  // Blocks between output lane j and the sample it needs at tap distance d,
  // for an unfolding factor of l lanes.
  function automatic int blk_delay(input int j, input int d, input int l);
    return (d - j + l - 1) / l;
  endfunction

  // Input lane that supplies the delayed operand of output lane j.
  function automatic int src_lane(input int j, input int d, input int l);
    return j + l * blk_delay(j, d, l) - d;
  endfunction

endpackage

// File: rtl/ufir_delay_line.sv
module ufir_delay_line #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout
);

  logic signed [DW-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else if (shift_en) stage[0] <= din;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else if (shift_en) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[DEPTH-1];

endmodule

// File: rtl/ufir_lane_mac.sv
module ufir_lane_mac #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [DW-1:0]    x_now,
  input  logic signed [DW-1:0]    x_dly,
  input  logic signed [CW-1:0]    coef,
  output logic signed [DW+CW:0]   y
);

  localparam int PW = DW + CW;
  localparam int OW = PW + 1;

  logic signed [PW-1:0] prod;
  logic signed [OW-1:0] sum;

  always_comb begin
    prod = coef * x_dly;
    sum  = {prod[PW-1], prod} + {{(OW-DW){x_now[DW-1]}}, x_now};
  end

  always_ff @(posedge clk) begin
    if (rst) y <= '0;
    else if (en) y <= sum;
  end

endmodule

// File: rtl/unfold2_tap_filter.sv
module unfold2_tap_filter #(
  parameter int LANES = 2,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int TAP   = 9
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [LANES*DW-1:0]         in_data,
  input  logic [CW-1:0]               coef,
  output logic                        out_valid,
  output logic [LANES*(DW+CW+1)-1:0]  out_data
);

  localparam int OW = DW + CW + 1;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else out_valid <= in_valid;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int QD = ufir_pkg::blk_delay(j, TAP, LANES);
    localparam int SL = ufir_pkg::src_lane(j, TAP, LANES);

    logic signed [DW-1:0] x_dly;
    logic signed [OW-1:0] y;

    ufir_delay_line #(.DW(DW), .DEPTH(QD)) dly_i (
      .clk      (clk),
      .rst      (rst),
      .shift_en (in_valid),
      .din      ($signed(in_data[SL*DW +: DW])),
      .dout     (x_dly)
    );

    ufir_lane_mac #(.DW(DW), .CW(CW)) mac_i (
      .clk   (clk),
      .rst   (rst),
      .en    (in_valid),
      .x_now ($signed(in_data[j*DW +: DW])),
      .x_dly (x_dly),
      .coef  ($signed(coef)),
      .y     (y)
    );

    assign out_data[j*OW +: OW] = y;
  end

endmodule

// File: rtl/unfold2_tap_filter_checker.sv
module unfold2_tap_filter_checker #(
  parameter int LANES = 2,
  parameter int DW    = 16,
  parameter int CW    = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic [LANES*DW-1:0]         in_data,
  input logic [CW-1:0]               coef,
  input logic                        out_valid,
  input logic [LANES*(DW+CW+1)-1:0]  out_data
);

  localparam int OW = DW + CW + 1;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0)); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2

  AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data)); // R6

  for (genvar j = 0; j < LANES; j++) begin : g_chk
    AST_ZERO_COEF_PASS: assert property (@(posedge clk) disable iff (rst)
      (in_valid && coef == '0) |=>
        (out_data[j*OW +: OW] ==
         {{(OW-DW){$past(in_data[j*DW+DW-1])}}, $past(in_data[j*DW +: DW])})); // R8
  end

endmodule

bind unfold2_tap_filter unfold2_tap_filter_checker #(
  .LANES (LANES),
  .DW    (DW),
  .CW    (CW)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .coef      (coef),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/unfold2_tap_filter_tb_top.sv
module unfold2_tap_filter_tb_top;

  localparam int OW = 33;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [15:0] coef = '0;
  logic        out_valid;
  logic [65:0] out_data;

  always #4 clk = ~clk;

  unfold2_tap_filter dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .coef(coef), .out_valid(out_valid), .out_data(out_data)
  );

  int     errors = 0;
  int     checks = 0;
  longint hist [0:4095];
  int     nblk = 0;
  logic   exp_valid = 1'b0;
  longint exp_y [2];
  string  tag_y [2];
  bit     done = 1'b0;

  function automatic longint lane_out(input int j);
    logic signed [OW-1:0] v;
    v = out_data[j*OW +: OW];
    return longint'(v);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Compare outputs from the previous edge, then drive the next cycle.
  task automatic step(input bit v, input logic signed [15:0] e,
                      input logic signed [15:0] o, input logic signed [15:0] c,
                      input string tagd);
    @(negedge clk);
    chk("R2 out_valid", longint'(out_valid), longint'(exp_valid));
    for (int j = 0; j < 2; j++) chk(tag_y[j], lane_out(j), exp_y[j]);
    in_valid = v;
    in_data  = {o, e};
    coef     = c;
    exp_valid = v;
    if (v) begin
      hist[2*nblk]   = longint'(e);
      hist[2*nblk+1] = longint'(o);
      for (int j = 0; j < 2; j++) begin
        int n;
        longint d;
        n = 2*nblk + j - 9;
        d = (n < 0) ? 0 : hist[n];
        exp_y[j] = longint'(c) * d + hist[2*nblk+j];
        if (tagd != "") tag_y[j] = tagd;
        else if (n < 0) tag_y[j] = "R5 fill";
        else tag_y[j] = (j == 0) ? "R3 even" : "R4 odd";
      end
      nblk++;
    end else begin
      tag_y[0] = "R6 hold";
      tag_y[1] = "R6 hold";
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1 reset valid", longint'(out_valid), 0);
    chk("R1 reset data", longint'(out_data == '0), 1);
    rst = 1'b0;
    nblk = 0;
    exp_valid = 1'b0;
    exp_y[0] = 0;
    exp_y[1] = 0;
    tag_y[0] = "R1 post";
    tag_y[1] = "R1 post";
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    // R5: fill phase with known values
    for (int i = 0; i < 7; i++) step(1'b1, 16'(100 + i), 16'(-200 - i), 16'sd3, "");
    step(1'b0, 16'sd0, 16'sd0, 16'sd3, "");
    step(1'b0, 16'sd5, 16'sd5, 16'sd7, "");
    // random traffic with idle gaps and changing coefficient
    for (int i = 0; i < 600; i++) begin
      bit v;
      v = ($urandom % 4) != 0;
      step(v, 16'($urandom), 16'($urandom), 16'($urandom), "");
    end
    // R7: extreme values across the lane boundary
    for (int i = 0; i < 6; i++)
      step(1'b1, 16'sh7FFF, -16'sh8000, -16'sh8000, "R7 extreme");
    for (int i = 0; i < 6; i++)
      step(1'b1, -16'sh8000, -16'sh8000, -16'sh8000, "R7 extreme");
    // R8: zero coefficient exposes lane positions
    step(1'b1, 16'sh1234, -16'sh0567, 16'sd0, "R8 lanes");
    // R9: coefficient changes every block
    for (int i = 0; i < 8; i++)
      step(1'b1, 16'(i * 311), 16'(-i * 97), 16'(i * 1000 - 4000), "R9 coef");
    // mid-stream reset, then refill
    do_reset();
    for (int i = 0; i < 8; i++)
      step(1'b1, 16'($urandom), 16'($urandom), 16'($urandom), "");
    step(1'b0, 16'sd0, 16'sd0, 16'sd0, "");
    step(1'b0, 16'sd0, 16'sd0, 16'sd0, "");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule